// File: doc/BRIEF.md
# SRAM-Emulated Ternary Match Engine

This block answers ternary lookups with small RAM arrays and simple logic, without any per-bit ternary comparator. The table is split into layers, and each layer owns a fixed group of entries. The search key is cut into equal subwords. In every layer, each subword addresses two arrays at the same time. The first is a one-bit presence array, which says whether that subword value occurs in the partition. The second is an entry-row array, which says which of the layer's entries accept that subword value.

Within a layer, the presence bits are reduced to one gate bit. The entry rows are ANDed bit by bit. The lowest surviving bit gives the layer's candidate. A second encoder across the layers then picks the candidate of the lowest-numbered layer. The result is the global entry number, layer times entries-per-layer plus the bit position, together with a hit flag.

Ternary entries are expanded to binary subwords outside the block and loaded through the write port. The search result is registered. Every state change is gated by a clock-enable input, which stands in for clock gating of idle logic.

Top module: `sram_ternary_match`

## Requirements
- R1: After reset, every presence bit and every entry-row bit is 0, and the registered result shows hit=0 and address 0. A search on the empty arrays therefore misses.
- R2: The result of a search is visible one cycle after the clock edge that samples the key. Before that edge the outputs still show the previous result.
- R3: If the presence bit addressed by any subword of a layer is 0, that layer produces no candidate, even when its entry rows share set bits.
- R4: An entry of a layer matches only if its bit is 1 in the entry rows addressed by all subwords. A loaded ternary table thus gives the same hits as a direct comparison of key and entry under a don't-care mask.
- R5: When several entries of one layer match, the lowest bit position wins.
- R6: When several layers hit, the lowest-numbered layer wins. The reported address is layer*K + bit, so entry 0 is bit 0 of layer 0.
- R7: When no layer hits, the result shows hit=0 and address 0.
- R8: While `outDisable` is 1, both result outputs are released to high impedance, and no write and no search takes place.
- R9: While `clkEn` is 0, no write takes place and the registered result holds its value.
- R10: With `outDisable`=0, `clkEn`=1 and `rdNotWr`=0, a clock edge stores `wrValid` into the presence bit at (`wrLayer`, `wrPart`, `wrRow`) and `wrEntries` into the entry row at the same place. With `rdNotWr`=1 the edge performs a search instead. Subword p is key bits [p*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Enables every state change |
| outDisable | input | 1 | 1: outputs at high impedance and all operations blocked |
| rdNotWr | input | 1 | 1: search, 0: write |
| searchKey | input | NUM_SUB*SUB_W | Key to look up |
| wrLayer | input | LAYER_W | Layer to load |
| wrPart | input | PART_W | Partition (subword index) to load |
| wrRow | input | SUB_W | Row, equal to the subword value |
| wrValid | input | 1 | Presence bit to store |
| wrEntries | input | ENT_PER_LAYER | Entry row to store |
| matchValid | output | 1 | Hit flag, high impedance while disabled |
| matchAddr | output | ADDR_W | Winning entry number, high impedance while disabled |

## Verification
A corrupted presence or entry-row bit changes the answer of the very next search that touches that row. It shows up as a missed hit, a spurious hit or a different winning address. A sweep over every key value against a direct ternary comparison exposes it within one sweep. Wrong priority in either encoder shows as the wrong address on any key that hits several entries. A bad strobe decode shows as a write that lands while the block is disabled or gated, or as a result that changes while it should hold. Both appear one cycle later.

// File: rtl/stm_pkg.sv
package stm_pkg;
  typedef struct packed {
    logic doWrite;
    logic doSearch;
  } stm_strobe_t;
endpackage

// File: rtl/stm_control.sv
module stm_control
  import stm_pkg::*;
(
  input  logic        clkEn,
  input  logic        outDisable,
  input  logic        rdNotWr,
  output stm_strobe_t strb,
  output logic        drvEn
);
  logic active;

  always_comb begin
    active        = clkEn && !outDisable;
    strb.doSearch = active && rdNotWr;
    strb.doWrite  = active && !rdNotWr;
    drvEn         = !outDisable;
  end
endmodule

// File: rtl/stm_layer.sv
module stm_layer
  import stm_pkg::*;
#(
  parameter int NUM_SUB = 2,
  parameter int SUB_W   = 2,
  parameter int K       = 2,
  localparam int ROWS   = 1 << SUB_W,
  localparam int PART_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int KIDX_W = (K > 1) ? $clog2(K) : 1,
  localparam int KEY_W  = NUM_SUB * SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stm_strobe_t       strb,
  input  logic              wrSel,
  input  logic [PART_W-1:0] wrPart,
  input  logic [SUB_W-1:0]  wrRow,
  input  logic              wrValid,
  input  logic [K-1:0]      wrEntries,
  input  logic [KEY_W-1:0]  searchKey,
  output logic              layerHit,
  output logic [KIDX_W-1:0] layerIdx
);
  logic [NUM_SUB-1:0][ROWS-1:0]         vmMem;
  logic [NUM_SUB-1:0][ROWS-1:0][K-1:0]  oatMem;
  logic [NUM_SUB-1:0]                   vmBit;
  logic [K-1:0]                         andRow;
  logic                                 partOk;

  assign partOk = int'(wrPart) < NUM_SUB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vmMem  <= '0;
      oatMem <= '0;
    end else if (strb.doWrite && wrSel && partOk) begin
      vmMem[wrPart][wrRow]  <= wrValid;
      oatMem[wrPart][wrRow] <= wrEntries;
    end
  end

  always_comb begin
    andRow = '1;
    for (int p = 0; p < NUM_SUB; p++) begin
      vmBit[p] = vmMem[p][searchKey[p*SUB_W +: SUB_W]];
      andRow   = andRow & oatMem[p][searchKey[p*SUB_W +: SUB_W]];
    end
    layerHit = (&vmBit) && (|andRow);
    layerIdx = '0;
    for (int b = K - 1; b >= 0; b--) begin
      if (andRow[b]) layerIdx = KIDX_W'(b);
    end
  end

  // R10: a write stores the presence bit at the addressed place
  a_r10_vm_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite && wrSel && partOk) |=> vmMem[$past(wrPart)][$past(wrRow)] == $past(wrValid));

  // R9: with no write strobe the arrays keep their contents
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doWrite && wrSel) |=> $stable(vmMem) && $stable(oatMem));
endmodule

// File: rtl/stm_datapath.sv
module stm_datapath
  import stm_pkg::*;
#(
  parameter int NUM_SUB = 2,
  parameter int SUB_W   = 2,
  parameter int K       = 2,
  parameter int L       = 2,
  localparam int PART_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int LAYER_W = (L > 1) ? $clog2(L) : 1,
  localparam int KIDX_W  = (K > 1) ? $clog2(K) : 1,
  localparam int ADDR_W  = (L * K > 1) ? $clog2(L * K) : 1,
  localparam int KEY_W   = NUM_SUB * SUB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  stm_strobe_t        strb,
  input  logic [KEY_W-1:0]   searchKey,
  input  logic [LAYER_W-1:0] wrLayer,
  input  logic [PART_W-1:0]  wrPart,
  input  logic [SUB_W-1:0]   wrRow,
  input  logic               wrValid,
  input  logic [K-1:0]       wrEntries,
  output logic               resValid,
  output logic [ADDR_W-1:0]  resAddr
);
  logic [L-1:0]              layerHit;
  logic [L-1:0][KIDX_W-1:0]  layerIdx;
  logic                      nextValid;
  logic [ADDR_W-1:0]         nextAddr;

  for (genvar li = 0; li < L; li++) begin : g_layer
    stm_layer #(.NUM_SUB(NUM_SUB), .SUB_W(SUB_W), .K(K)) uLayer (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .wrSel    (int'(wrLayer) == li),
      .wrPart   (wrPart),
      .wrRow    (wrRow),
      .wrValid  (wrValid),
      .wrEntries(wrEntries),
      .searchKey(searchKey),
      .layerHit (layerHit[li]),
      .layerIdx (layerIdx[li])
    );
  end

  always_comb begin
    nextValid = 1'b0;
    nextAddr  = '0;
    for (int li = L - 1; li >= 0; li--) begin
      if (layerHit[li]) begin
        nextValid = 1'b1;
        nextAddr  = ADDR_W'(li * K + int'(layerIdx[li]));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resAddr  <= '0;
    end else if (strb.doSearch) begin
      resValid <= nextValid;
      resAddr  <= nextAddr;
    end
  end

  // R9: without a search strobe the result holds
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doSearch |=> $stable(resValid) && $stable(resAddr));

  // R6: a hit in layer 0 always wins with an address inside layer 0
  a_r6_layer0_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doSearch && layerHit[0]) |=> resValid && (int'(resAddr) < K));

  // R7: no layer hit gives a cleared result
  a_r7_miss_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doSearch && layerHit == '0) |=> !resValid && resAddr == '0);
endmodule

// File: rtl/sram_ternary_match.sv
module sram_ternary_match
  import stm_pkg::*;
#(
  parameter int NUM_SUB       = 2,
  parameter int SUB_W         = 2,
  parameter int ENT_PER_LAYER = 2,
  parameter int NUM_LAYERS    = 2,
  localparam int PART_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
  localparam int ADDR_W  = (NUM_LAYERS * ENT_PER_LAYER > 1) ? $clog2(NUM_LAYERS * ENT_PER_LAYER) : 1,
  localparam int KEY_W   = NUM_SUB * SUB_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clkEn,
  input  logic                     outDisable,
  input  logic                     rdNotWr,
  input  logic [KEY_W-1:0]         searchKey,
  input  logic [LAYER_W-1:0]       wrLayer,
  input  logic [PART_W-1:0]        wrPart,
  input  logic [SUB_W-1:0]         wrRow,
  input  logic                     wrValid,
  input  logic [ENT_PER_LAYER-1:0] wrEntries,
  output wire                      matchValid,
  output wire  [ADDR_W-1:0]        matchAddr
);
  stm_strobe_t        strb;
  logic               drvEn;
  logic               resValid;
  logic [ADDR_W-1:0]  resAddr;

  stm_control uCtrl (
    .clkEn     (clkEn),
    .outDisable(outDisable),
    .rdNotWr   (rdNotWr),
    .strb      (strb),
    .drvEn     (drvEn)
  );

  stm_datapath #(
    .NUM_SUB(NUM_SUB), .SUB_W(SUB_W), .K(ENT_PER_LAYER), .L(NUM_LAYERS)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .searchKey(searchKey),
    .wrLayer  (wrLayer),
    .wrPart   (wrPart),
    .wrRow    (wrRow),
    .wrValid  (wrValid),
    .wrEntries(wrEntries),
    .resValid (resValid),
    .resAddr  (resAddr)
  );

  assign matchValid = drvEn ? resValid : 1'bz;
  assign matchAddr  = drvEn ? resAddr : {ADDR_W{1'bz}};

  // R8: a disabled block issues no strobe
  a_r8_no_strobe_off: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> !strb.doWrite && !strb.doSearch);
endmodule

// File: tb/sram_ternary_match_test.sv
module sram_ternary_match_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       outDisable = 1'b0;
  logic       rdNotWr = 1'b1;
  logic [3:0] searchKey = '0;
  logic       wrLayer = 1'b0;
  logic       wrPart = 1'b0;
  logic [1:0] wrRow = '0;
  logic       wrValid = 1'b0;
  logic [1:0] wrEntries = '0;
  wire        matchValid;
  wire  [1:0] matchAddr;

  int checks = 0;
  int errors = 0;

  logic [3:0] eVal  [4];
  logic [3:0] eCare [4];

  sram_ternary_match uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .outDisable(outDisable),
    .rdNotWr(rdNotWr), .searchKey(searchKey), .wrLayer(wrLayer),
    .wrPart(wrPart), .wrRow(wrRow), .wrValid(wrValid), .wrEntries(wrEntries),
    .matchValid(matchValid), .matchAddr(matchAddr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkResult(input string req, input bit expV, input int expA);
    check(matchValid === expV, {req, " valid"}, int'(matchValid), int'(expV));
    check(matchAddr === 2'(expA), {req, " addr"}, int'(matchAddr), expA);
  endtask

  task automatic writeRow(input int l, input int p, input int r, input bit v, input logic [1:0] ents);
    @(negedge clk);
    clkEn = 1'b1; rdNotWr = 1'b0;
    wrLayer = l[0]; wrPart = p[0]; wrRow = r[1:0]; wrValid = v; wrEntries = ents;
    @(negedge clk);
    clkEn = 1'b0; rdNotWr = 1'b1;
  endtask

  task automatic doSearch(input logic [3:0] key);
    @(negedge clk);
    clkEn = 1'b1; rdNotWr = 1'b1; searchKey = key;
    @(negedge clk);
    clkEn = 1'b0;
  endtask

  function automatic void refSearch(input logic [3:0] key, output bit hit, output int addr);
    hit = 1'b0; addr = 0;
    for (int e = 3; e >= 0; e--) begin
      if (((key ^ eVal[e]) & eCare[e]) == 4'b0) begin
        hit = 1'b1; addr = e;
      end
    end
  endfunction

  task automatic testReset();
    checkResult("R1 reset", 1'b0, 0);
    doSearch(4'b0101);
    checkResult("R1 empty search", 1'b0, 0);
  endtask

  task automatic loadTable();
    for (int l = 0; l < 2; l++)
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 4; r++) begin
          logic [1:0] ents;
          for (int b = 0; b < 2; b++) begin
            logic [1:0] v, c;
            v = eVal[l*2+b][p*2 +: 2];
            c = eCare[l*2+b][p*2 +: 2];
            ents[b] = ((2'(r) ^ v) & c) == 2'b0;
          end
          writeRow(l, p, r, |ents, ents);
        end
  endtask

  task automatic testSweep();
    for (int k = 0; k < 16; k++) begin
      bit h; int a;
      refSearch(4'(k), h, a);
      doSearch(4'(k));
      checkResult("R4 R5 R6 R7 R10 sweep", h, a);
    end
  endtask

  task automatic testGate();
    writeRow(1, 0, 1, 1'b0, 2'b11);
    doSearch(4'b1101);
    checkResult("R3 gated layer", 1'b0, 0);
    doSearch(4'b0101);
    checkResult("R3 other layer", 1'b1, 0);
    writeRow(1, 0, 1, 1'b1, 2'b11);
    doSearch(4'b1101);
    checkResult("R3 restored", 1'b1, 2);
  endtask

  task automatic testLatency();
    doSearch(4'b0001);
    checkResult("R2 first", 1'b1, 1);
    @(negedge clk);
    clkEn = 1'b1; searchKey = 4'b1000;
    #1;
    checkResult("R2 before edge", 1'b1, 1);
    @(negedge clk);
    clkEn = 1'b0;
    checkResult("R2 after edge", 1'b0, 0);
  endtask

  task automatic testClkEn();
    doSearch(4'b1101);
    @(negedge clk);
    clkEn = 1'b0; rdNotWr = 1'b0;
    wrLayer = 1'b1; wrPart = 1'b0; wrRow = 2'b01; wrValid = 1'b0; wrEntries = 2'b00;
    @(negedge clk);
    rdNotWr = 1'b1; searchKey = 4'b1000;
    @(negedge clk);
    checkResult("R9 result held", 1'b1, 2);
    doSearch(4'b1101);
    checkResult("R9 write blocked", 1'b1, 2);
  endtask

  task automatic testDisable();
    doSearch(4'b1101);
    @(negedge clk);
    outDisable = 1'b1; clkEn = 1'b1; rdNotWr = 1'b0;
    wrLayer = 1'b1; wrPart = 1'b0; wrRow = 2'b01; wrValid = 1'b0; wrEntries = 2'b00;
    #1;
    check(matchValid !== 1'b1, "R8 output released", int'(matchValid), 0);
    @(negedge clk);
    rdNotWr = 1'b1; searchKey = 4'b1000;
    @(negedge clk);
    outDisable = 1'b0; clkEn = 1'b0;
    #1;
    checkResult("R8 no search while off", 1'b1, 2);
    doSearch(4'b1101);
    checkResult("R8 write blocked", 1'b1, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    eVal[0] = 4'b0100; eCare[0] = 4'b1100;
    eVal[1] = 4'b0001; eCare[1] = 4'b1011;
    eVal[2] = 4'b1101; eCare[2] = 4'b1111;
    eVal[3] = 4'b0001; eCare[3] = 4'b0011;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadTable();
    testSweep();
    testGate();
    testLatency();
    testClkEn();
    testDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule